// File: doc/BRIEF.md
# Two-Channel Instruction Breakpoint Unit

This unit watches the instruction-fetch address stream of a 32-bit processor and raises a break request toward the debug logic. Two compare channels, A and B, each hold one 32-bit address. A valid fetch whose address is exactly equal to a channel's compare register is a match for that channel. Software programs the compare registers, a control register, an execution-count limit and a status register through a small word-wide register port. Writes take effect at the clock edge. Reads are combinational.

Channel A always breaks before the matched instruction runs. Channel B can break either before or after its matched instruction. An after-break is held pending until the next instruction-retire strobe. The control register also sets how the two channels combine:

- In independent mode, each channel breaks on its own.
- In sequential mode, a channel A match only arms the unit. A later channel B match then produces the break.

Channel B can also require a programmed number of matches before it fires. The break output is a one-cycle pulse for each qualifying event. A write-one-to-clear status register records which channel caused each break.

Top module: `brk_unit`

## Requirements
- R1: After reset every register reads 0 and `brk_out` is low while no fetch or retire is presented.
- R2: The control register is at offset 0. Bit 6 chooses after-execution for channel B, bit 3 chooses sequential mode, and bit 0 enables the channel B match count. Its other bits read 0, and writes to them are ignored. The other offsets are: 1 is the 12-bit count limit, 2 is status, 3 is the channel A address and 4 is the channel B address.
- R3: In independent mode, a valid fetch equal to the channel A address raises `brk_out` in the same cycle. With bit 6 and bit 0 clear, a valid fetch equal to the channel B address also raises `brk_out` in the same cycle.
- R4: When bit 6 is set, a channel B break is not raised in its match cycle. It is raised on the first `retire` pulse in a later cycle, once only.
- R5: In sequential mode, a channel A match never breaks and sets an armed flag. A channel B match while not armed is ignored. A channel B match while armed breaks and clears the flag.
- R6: When bit 0 is set, channel B breaks only on the match whose running count equals the count limit. The running count returns to 0 on that break and on any write to the count limit. A limit of 0 never breaks.
- R7: When `fetch_valid` is low, no address matches.
- R8: Status bit 0 is set by a channel A break and bit 1 by a channel B break. Writing 1 to a status bit clears it. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_addr | input | 32 | Instruction-fetch address |
| retire | input | 1 | Instruction-retire strobe |
| brk_out | output | 1 | Break request pulse |

## Verification
Before-execution breaks and read data are combinational, so they are due in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples two nanoseconds later, before the rising edge that commits state. Register writes, arming, count steps and status updates take effect at that rising edge, so they are seen in the next sampling window. An after-execution break is due in the window of the first later cycle that carries `retire`. A reference model in the bench is stepped once per cycle after the comparison, which keeps each expected value aligned with the cycle the design must produce it.

// File: rtl/brk_unit.sv
module brk_unit #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic          retire,
  output logic          brk_out
);
  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_LIM  = 3'd1;
  localparam logic [2:0] OFS_STAT = 3'd2;
  localparam logic [2:0] OFS_CMPA = 3'd3;
  localparam logic [2:0] OFS_CMPB = 3'd4;

  logic [AW-1:0] cmp_a, cmp_b;
  logic          after_q, seq_q, cen_q;
  logic [CW-1:0] cnt_lim, cnt_q;
  logic          armed_q, pend_q;
  logic [1:0]    stat_q;

  wire match_a = fetch_valid && (fetch_addr == cmp_a);
  wire match_b = fetch_valid && (fetch_addr == cmp_b);
  wire b_hit   = match_b && (!seq_q || armed_q);
  wire [CW:0] cnt_inc = {1'b0, cnt_q} + (CW+1)'(1);
  wire b_fire  = b_hit && (!cen_q || (cnt_inc == {1'b0, cnt_lim}));
  wire a_brk   = match_a && !seq_q;
  wire b_brk   = (b_fire && !after_q) || (pend_q && retire);

  assign brk_out = a_brk || b_brk;

  wire wr_ctrl = reg_we && (reg_addr == OFS_CTRL);
  wire wr_lim  = reg_we && (reg_addr == OFS_LIM);
  wire wr_stat = reg_we && (reg_addr == OFS_STAT);
  wire [1:0] stat_clr = wr_stat ? reg_wdata[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_a   <= '0;
      cmp_b   <= '0;
      after_q <= 1'b0;
      seq_q   <= 1'b0;
      cen_q   <= 1'b0;
      cnt_lim <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      stat_q  <= 2'b00;
    end else begin
      if (reg_we && reg_addr == OFS_CMPA) cmp_a <= reg_wdata[AW-1:0];
      if (reg_we && reg_addr == OFS_CMPB) cmp_b <= reg_wdata[AW-1:0];
      if (wr_ctrl) begin
        after_q <= reg_wdata[6];
        seq_q   <= reg_wdata[3];
        cen_q   <= reg_wdata[0];
      end
      if (wr_lim) cnt_lim <= reg_wdata[CW-1:0];

      if (wr_lim || b_fire)     cnt_q <= '0;
      else if (b_hit && cen_q)  cnt_q <= cnt_inc[CW-1:0];

      armed_q <= seq_q && ((armed_q && !b_fire) || match_a);
      pend_q  <= (pend_q && !retire) || (b_fire && after_q);
      stat_q  <= (stat_q & ~stat_clr) | {b_brk, a_brk};
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL: reg_rdata = DW'({after_q, 2'b00, seq_q, 2'b00, cen_q});
      OFS_LIM:  reg_rdata = DW'(cnt_lim);
      OFS_STAT: reg_rdata = DW'(stat_q);
      OFS_CMPA: reg_rdata = DW'(cmp_a);
      OFS_CMPB: reg_rdata = DW'(cmp_b);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/brk_unit_chk.sv
module brk_unit_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetch_valid,
  input logic          retire,
  input logic          brk_out,
  input logic          seq_q,
  input logic          after_q,
  input logic          cen_q,
  input logic          match_b,
  input logic          pend_q,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] cnt_lim,
  input logic [1:0]    stat_q
);
  p_novalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && !retire) |-> !brk_out);

  p_seq_a_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_q && !match_b && !(pend_q && retire)) |-> !brk_out);

  p_after_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (after_q && seq_q && !retire) |-> !brk_out);

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cen_q && cnt_lim != '0) |-> (cnt_q < cnt_lim));

  p_stat_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_out |=> (stat_q != 2'b00));
endmodule

bind brk_unit brk_unit_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .retire(retire),
  .brk_out(brk_out), .seq_q(seq_q), .after_q(after_q), .cen_q(cen_q),
  .match_b(match_b), .pend_q(pend_q), .cnt_q(cnt_q), .cnt_lim(cnt_lim),
  .stat_q(stat_q)
);

// File: tb/brk_unit_bench.sv
module brk_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        retire = 1'b0;
  logic        brk_out;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  localparam logic [31:0] ADR_A = 32'h0000_1000;
  localparam logic [31:0] ADR_B = 32'h0000_2000;
  localparam logic [31:0] ADR_X = 32'h0000_3000;

  always #4 clk = ~clk;

  brk_unit u_brk_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .retire(retire), .brk_out(brk_out)
  );

  logic [31:0] m_a, m_b;
  bit          m_after, m_seq, m_cen, m_armed, m_pend;
  int          m_lim, m_cnt;
  logic [1:0]  m_stat;

  task automatic m_reset();
    m_a = '0; m_b = '0; m_after = 0; m_seq = 0; m_cen = 0;
    m_armed = 0; m_pend = 0; m_lim = 0; m_cnt = 0; m_stat = 2'b00;
  endtask

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic cyc(input bit we, input logic [2:0] ad, input logic [31:0] wd,
                     input bit v, input logic [31:0] fa, input bit r,
                     input int exp_d, input string tag);
    bit ma, mb, ahit, bhit, bfire, abrk, bbrk, mexp;
    reg_we = we; reg_addr = ad; reg_wdata = wd;
    fetch_valid = v; fetch_addr = fa; retire = r;
    #2;
    ma = v && (fa == m_a);
    mb = v && (fa == m_b);
    ahit = ma;
    bhit = mb && (!m_seq || m_armed);
    bfire = bhit && (!m_cen || (m_cnt + 1 == m_lim));
    abrk = ahit && !m_seq;
    bbrk = (bfire && !m_after) || (m_pend && r);
    mexp = abrk || bbrk;
    chk({31'b0, brk_out}, {31'b0, (exp_d < 0) ? mexp : (exp_d != 0)}, tag);
    if (we && ad == 3'd1)   m_cnt = 0;
    else if (bfire)         m_cnt = 0;
    else if (bhit && m_cen) m_cnt = (m_cnt + 1) % 4096;
    m_armed = m_seq && ((m_armed && !bfire) || ma);
    m_pend = (m_pend && !r) || (bfire && m_after);
    m_stat = (m_stat & ~((we && ad == 3'd2) ? wd[1:0] : 2'b00)) | {bbrk, abrk};
    if (we) begin
      case (ad)
        3'd0: begin m_after = wd[6]; m_seq = wd[3]; m_cen = wd[0]; end
        3'd1: m_lim = int'(wd[11:0]);
        3'd3: m_a = wd;
        3'd4: m_b = wd;
        default: ;
      endcase
    end
    @(negedge clk);
    reg_we = 0; fetch_valid = 0; retire = 0;
  endtask

  task automatic wr(input logic [2:0] ad, input logic [31:0] wd);
    cyc(1, ad, wd, 0, '0, 0, 0, "write idle");
  endtask

  task automatic rd(input logic [2:0] ad, input logic [31:0] exp, input string tag);
    reg_addr = ad;
    #1;
    chk(reg_rdata, exp, tag);
    @(negedge clk);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        bad++; total++;
        $display("FAIL watchdog got=%0d exp<=200000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(3'd0, 32'h0, "R1 ctrl reset");
    rd(3'd1, 32'h0, "R1 limit reset");
    rd(3'd2, 32'h0, "R1 status reset");
    rd(3'd3, 32'h0, "R1 addr A reset");
    cyc(0, 0, 0, 0, '0, 0, 0, "R1 idle no break");

    wr(3'd3, ADR_A);
    wr(3'd4, ADR_B);
    rd(3'd3, ADR_A, "R2 addr A readback");
    rd(3'd4, ADR_B, "R2 addr B readback");
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, 32'h49, "R2 reserved bits read zero");
    wr(3'd0, 32'h0);

    cyc(0, 0, 0, 1, ADR_A, 0, 1, "R3 channel A break");
    cyc(0, 0, 0, 1, ADR_B, 0, 1, "R3 channel B break");
    cyc(0, 0, 0, 1, ADR_X, 0, 0, "R3 no match");
    cyc(0, 0, 0, 0, ADR_A, 0, 0, "R7 invalid fetch");
    rd(3'd2, 32'h3, "R8 both status bits");
    wr(3'd2, 32'h1);
    rd(3'd2, 32'h2, "R8 clear A flag");
    wr(3'd2, 32'h2);
    rd(3'd2, 32'h0, "R8 clear B flag");

    wr(3'd0, 32'h40);
    cyc(0, 0, 0, 1, ADR_B, 1, 0, "R4 no break in match cycle");
    cyc(0, 0, 0, 0, '0, 0, 0, "R4 wait without retire");
    cyc(0, 0, 0, 0, '0, 1, 1, "R4 break on retire");
    cyc(0, 0, 0, 0, '0, 1, 0, "R4 only once");
    cyc(1, 3'd2, 32'h3, 1, ADR_A, 0, 1, "R8 set wins over clear");
    rd(3'd2, 32'h1, "R8 set wins over clear");
    wr(3'd2, 32'h3);

    wr(3'd0, 32'h08);
    cyc(0, 0, 0, 1, ADR_B, 0, 0, "R5 B unarmed ignored");
    cyc(0, 0, 0, 1, ADR_A, 0, 0, "R5 A arms silently");
    cyc(0, 0, 0, 1, ADR_B, 0, 1, "R5 armed B breaks");
    cyc(0, 0, 0, 1, ADR_B, 0, 0, "R5 flag cleared");

    wr(3'd0, 32'h01);
    wr(3'd1, 32'd3);
    cyc(0, 0, 0, 1, ADR_B, 0, 0, "R6 match 1");
    cyc(0, 0, 0, 1, ADR_B, 0, 0, "R6 match 2");
    cyc(0, 0, 0, 1, ADR_B, 0, 1, "R6 match 3 breaks");
    cyc(0, 0, 0, 1, ADR_B, 0, 0, "R6 count restarted");
    wr(3'd1, 32'd2);
    cyc(0, 0, 0, 1, ADR_B, 0, 0, "R6 write restarts count");
    cyc(0, 0, 0, 1, ADR_B, 0, 1, "R6 limit 2 breaks");
    wr(3'd1, 32'd0);
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 1, ADR_B, 0, 0, "R6 limit zero");
    wr(3'd2, 32'h3);

    for (int blk = 0; blk < 30; blk++) begin
      logic [31:0] c;
      c = $urandom;
      wr(3'd0, c);
      wr(3'd1, $urandom_range(0, 4));
      for (int k = 0; k < 120; k++) begin
        int sel;
        logic [31:0] fa;
        sel = $urandom_range(0, 2);
        fa = (sel == 0) ? ADR_A : (sel == 1) ? ADR_B : ADR_X;
        cyc(0, 0, 0, $urandom_range(0, 3) != 0, fa, $urandom_range(0, 2) == 0, -1,
            "R3 R4 R5 R6 random stream");
      end
      rd(3'd2, {30'b0, m_stat}, "R8 random status");
      wr(3'd2, 32'h3);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule